// File: doc/BRIEF.md
# Trace Cache Front End with Programmable Miss Penalty

This block sits in the fetch stage of a wide superscalar core and caches traces: runs of up to sixteen committed instructions, each indexed by the fetch address of its first instruction. Each accepted fetch request looks up the cache. A hit hands the whole trace, its length and its fall-through address to the fetch queue one cycle later, and marks the way as most recently used.

A miss sends the request down the conventional instruction path. The block presents the address on `conv_addr` and waits for the number of cycles held on `miss_delay`. This wait stands for the extra decode work that a conventional fetch needs. The block then writes a single instruction taken from `conv_insn` into the fetch queue. Only one miss can be in flight, and `fetch_busy` stays high until it resolves.

A fill unit writes finished traces through a separate port. Two running counters count hits and misses, so the hit rate can be derived from them.

Top module: `trace_cache`

## Requirements
- R1: After reset no line is valid, `hit_count` and `miss_count` are zero, and `fetch_busy` and `fq_valid` are low.
- R2: A fetch accepted in cycle T whose address matches a valid line gives `fq_valid`=1 and `fq_hit`=1 in cycle T+1. In that cycle `fq_count` is the stored length, `fq_next` is the stored fall-through address, and lane i of `fq_insns` (bits i*32 up to i*32+31) is stored instruction i, for i below the length.
- R3: Address bits [7:2] select one of 64 sets. All other address bits form the tag. Up to four traces with the same set bits and different tags are all hit.
- R4: A fetch accepted in cycle T that misses raises `fetch_busy` from cycle T+1. `conv_addr` holds the request address while busy. With D = `miss_delay` sampled in cycle T, the delivery appears in cycle T+D+2: `fq_valid`=1, `fq_hit`=0, `fq_count`=1, lane 0 = `conv_insn`, and `fq_next` = address+4. `fetch_busy` is low in that same cycle.
- R5: `miss_delay` is a runtime input. Values of 0, 2 and 5 each give the R4 timing.
- R6: A fetch request raised while `fetch_busy` is high is ignored. It causes no delivery, changes no counter and does not alter the outstanding miss.
- R7: A fill whose address is already cached overwrites that way, and the other ways of the set are kept.
- R8: A fill for a new address takes the lowest-numbered invalid way of its set. If the set is full, it takes the way whose last hit or fill is oldest.
- R9: Each accepted fetch adds one to `hit_count` on a hit or to `miss_count` on a miss.
- R10: `fill_count` is the trace length, from 1 to 16, written as a plain binary value. A hit returns that same length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_delay | input | 8 | Extra cycles charged to a miss |
| fetch_req | input | 1 | Fetch request, accepted when not busy |
| fetch_addr | input | 32 | Fetch address |
| fetch_busy | output | 1 | A miss is outstanding |
| fill_valid | input | 1 | Write a trace |
| fill_addr | input | 32 | Start address of the trace being written |
| fill_count | input | 5 | Instructions in the trace (1..16) |
| fill_next | input | 32 | Fall-through address after the trace |
| fill_insns | input | 512 | Sixteen 32-bit instruction lanes |
| conv_addr | output | 32 | Address on the conventional path |
| conv_insn | input | 32 | Instruction from the conventional path |
| fq_valid | output | 1 | Fetch queue write strobe |
| fq_hit | output | 1 | Delivery came from the trace cache |
| fq_count | output | 5 | Instructions delivered |
| fq_next | output | 32 | Next fetch address |
| fq_insns | output | 512 | Delivered instruction lanes |
| hit_count | output | 32 | Hits so far |
| miss_count | output | 32 | Misses so far |

## Verification
The hardest state to reach is a full set in which the recency order points at a way other than the one a new fill matches. Only that state tells overwrite-on-match apart from plain LRU replacement. The stimulus table fills all four ways of one set and then fetches them in a chosen order, so the matching way is not the oldest. It then refills that trace with a new length and fetches the older neighbour, which has to survive. A second stubborn case is a request that arrives while a miss is counting down. A directed test holds a hitting address on the request pins during the whole wait, and then checks both the counters and the arrival cycle of the miss.

// File: rtl/tc_pkg.sv
package tc_pkg;
  // countdown state of the conventional-path timer
  typedef enum logic {TMR_IDLE = 1'b0, TMR_WAIT = 1'b1} tmr_state_e;
  // log2 of the instruction size in bytes
  localparam int unsigned TC_INSN_SHIFT = 2;
endpackage

// File: rtl/tc_tag_store.sv
module tc_tag_store #(
  parameter int unsigned WAYS   = 4,
  parameter int unsigned SETS   = 64,
  parameter int unsigned TAG_W  = 26,
  parameter int unsigned LEN_W  = 5,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned TS_W   = 16,
  localparam int unsigned IDX_W = $clog2(SETS),
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TS_W-1:0]   now,
  input  logic              lk_en,
  input  logic [IDX_W-1:0]  lk_set,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic              lk_hit,
  output logic [WAY_W-1:0]  lk_way,
  output logic [LEN_W-1:0]  lk_count,
  output logic [ADDR_W-1:0] lk_next,
  input  logic              fl_en,
  input  logic [IDX_W-1:0]  fl_set,
  input  logic [TAG_W-1:0]  fl_tag,
  input  logic [LEN_W-1:0]  fl_count,
  input  logic [ADDR_W-1:0] fl_next,
  output logic [WAY_W-1:0]  fl_way
);
  logic [WAYS-1:0]   valid_q [SETS];
  logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
  logic [LEN_W-1:0]  len_q   [SETS][WAYS];
  logic [ADDR_W-1:0] nxt_q   [SETS][WAYS];
  logic [TS_W-1:0]   ts_q    [SETS][WAYS];

  logic [WAYS-1:0] lk_vec, fl_match;

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      lk_vec[w]   = valid_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
      fl_match[w] = valid_q[fl_set][w] && (tag_q[fl_set][w] == fl_tag);
    end
  end

  always_comb begin
    lk_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (lk_vec[w]) lk_way = WAY_W'(w);
  end

  assign lk_hit   = |lk_vec;
  assign lk_count = len_q[lk_set][lk_way];
  assign lk_next  = nxt_q[lk_set][lk_way];

  // victim choice: matching way, else first invalid, else oldest stamp
  always_comb begin
    logic found;
    found  = 1'b0;
    fl_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (fl_match[w] && !found) begin
        fl_way = WAY_W'(w);
        found  = 1'b1;
      end
    for (int w = 0; w < WAYS; w++)
      if (!valid_q[fl_set][w] && !found) begin
        fl_way = WAY_W'(w);
        found  = 1'b1;
      end
    if (!found)
      for (int w = 1; w < WAYS; w++)
        if (ts_q[fl_set][w] < ts_q[fl_set][fl_way]) fl_way = WAY_W'(w);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
    end else if (fl_en) begin
      valid_q[fl_set][fl_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (lk_en && lk_hit) ts_q[lk_set][lk_way] <= now;
    if (fl_en) begin
      tag_q[fl_set][fl_way] <= fl_tag;
      len_q[fl_set][fl_way] <= fl_count;
      nxt_q[fl_set][fl_way] <= fl_next;
      ts_q[fl_set][fl_way]  <= now;
    end
  end

  // overwrite-on-match keeps every tag unique within a set
  assert_unique_tag_R7: assert property (@(posedge clk) disable iff (rst)
    lk_en |-> $onehot0(lk_vec));
endmodule

// File: rtl/tc_data_ram.sv
module tc_data_ram #(
  parameter int unsigned WAYS   = 4,
  parameter int unsigned SETS   = 64,
  parameter int unsigned LINE_W = 512,
  localparam int unsigned IDX_W = $clog2(SETS),
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic                   clk,
  input  logic                   rd_en,
  input  logic [IDX_W-1:0]       rd_set,
  output logic [WAYS*LINE_W-1:0] rd_data,
  input  logic                   wr_en,
  input  logic [WAY_W-1:0]       wr_way,
  input  logic [IDX_W-1:0]       wr_set,
  input  logic [LINE_W-1:0]      wr_data
);
  // one simple dual-port memory per way
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [LINE_W-1:0] mem [SETS];
    logic [LINE_W-1:0] rd_q;
    always_ff @(posedge clk) begin
      if (wr_en && (wr_way == WAY_W'(w))) mem[wr_set] <= wr_data;
      if (rd_en) rd_q <= mem[rd_set];
    end
    assign rd_data[w*LINE_W +: LINE_W] = rd_q;
  end
endmodule

// File: rtl/tc_miss_timer.sv
module tc_miss_timer
  import tc_pkg::*;
#(
  parameter int unsigned DLY_W  = 8,
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [DLY_W-1:0]  delay,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] addr_q
);
  tmr_state_e       st_q;
  logic [DLY_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= TMR_IDLE;
      cnt_q  <= '0;
      addr_q <= '0;
    end else if (st_q == TMR_IDLE) begin
      if (start) begin
        st_q   <= TMR_WAIT;
        cnt_q  <= delay;
        addr_q <= start_addr;
      end
    end else if (cnt_q == '0) begin
      st_q <= TMR_IDLE;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy = (st_q == TMR_WAIT);
  assign done = busy && (cnt_q == '0);

  assert_countdown_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt_q != '0) |=> (busy && cnt_q == $past(cnt_q) - 1'b1 && $stable(addr_q)));
  assert_release_after_done_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy);
endmodule

// File: rtl/trace_cache.sv
module trace_cache
  import tc_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned INSN_W  = 32,
  parameter int unsigned MAX_LEN = 16,
  parameter int unsigned WAYS    = 4,
  parameter int unsigned SETS    = 64,
  parameter int unsigned DLY_W   = 8,
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned TS_W    = 16,
  localparam int unsigned IDX_W  = $clog2(SETS),
  localparam int unsigned TAG_W  = ADDR_W - IDX_W,
  localparam int unsigned LEN_W  = $clog2(MAX_LEN + 1),
  localparam int unsigned LINE_W = MAX_LEN * INSN_W,
  localparam int unsigned WAY_W  = $clog2(WAYS),
  localparam int unsigned LO     = TC_INSN_SHIFT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DLY_W-1:0]  miss_delay,
  input  logic              fetch_req,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              fetch_busy,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [LEN_W-1:0]  fill_count,
  input  logic [ADDR_W-1:0] fill_next,
  input  logic [LINE_W-1:0] fill_insns,
  output logic [ADDR_W-1:0] conv_addr,
  input  logic [INSN_W-1:0] conv_insn,
  output logic              fq_valid,
  output logic              fq_hit,
  output logic [LEN_W-1:0]  fq_count,
  output logic [ADDR_W-1:0] fq_next,
  output logic [LINE_W-1:0] fq_insns,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count
);
  logic [TS_W-1:0]        now_q;
  logic                   accept, lk_hit, tmr_done;
  logic [WAY_W-1:0]       lk_way, fl_way, way_q;
  logic [LEN_W-1:0]       lk_count;
  logic [ADDR_W-1:0]      lk_next, tmr_addr;
  logic [WAYS*LINE_W-1:0] rd_data;
  logic [INSN_W-1:0]      conv_q;

  // set bits sit just above the instruction offset; the rest is tag
  logic [IDX_W-1:0] lk_set, fl_set;
  logic [TAG_W-1:0] lk_tag, fl_tag;
  assign lk_set = fetch_addr[LO +: IDX_W];
  assign fl_set = fill_addr[LO +: IDX_W];
  assign lk_tag = {fetch_addr[ADDR_W-1:LO+IDX_W], fetch_addr[LO-1:0]};
  assign fl_tag = {fill_addr[ADDR_W-1:LO+IDX_W], fill_addr[LO-1:0]};

  assign accept = fetch_req && !fetch_busy;

  tc_tag_store #(
    .WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W), .LEN_W(LEN_W),
    .ADDR_W(ADDR_W), .TS_W(TS_W)
  ) u_tags (
    .clk(clk), .rst(rst), .now(now_q),
    .lk_en(accept), .lk_set(lk_set), .lk_tag(lk_tag),
    .lk_hit(lk_hit), .lk_way(lk_way), .lk_count(lk_count), .lk_next(lk_next),
    .fl_en(fill_valid), .fl_set(fl_set), .fl_tag(fl_tag),
    .fl_count(fill_count), .fl_next(fill_next), .fl_way(fl_way)
  );

  tc_data_ram #(.WAYS(WAYS), .SETS(SETS), .LINE_W(LINE_W)) u_data (
    .clk(clk), .rd_en(accept), .rd_set(lk_set), .rd_data(rd_data),
    .wr_en(fill_valid), .wr_way(fl_way), .wr_set(fl_set), .wr_data(fill_insns)
  );

  tc_miss_timer #(.DLY_W(DLY_W), .ADDR_W(ADDR_W)) u_timer (
    .clk(clk), .rst(rst), .start(accept && !lk_hit), .start_addr(fetch_addr),
    .delay(miss_delay), .busy(fetch_busy), .done(tmr_done), .addr_q(tmr_addr)
  );

  assign conv_addr = tmr_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      now_q      <= '0;
      fq_valid   <= 1'b0;
      fq_hit     <= 1'b0;
      fq_count   <= '0;
      fq_next    <= '0;
      way_q      <= '0;
      conv_q     <= '0;
      hit_count  <= '0;
      miss_count <= '0;
    end else begin
      now_q    <= now_q + 1'b1;
      fq_valid <= (accept && lk_hit) || tmr_done;
      if (accept && lk_hit) begin
        fq_hit    <= 1'b1;
        fq_count  <= lk_count;
        fq_next   <= lk_next;
        way_q     <= lk_way;
        hit_count <= hit_count + 1'b1;
      end else if (tmr_done) begin
        fq_hit   <= 1'b0;
        fq_count <= LEN_W'(1);
        fq_next  <= tmr_addr + ADDR_W'(1 << LO);
        conv_q   <= conv_insn;
      end
      if (accept && !lk_hit) miss_count <= miss_count + 1'b1;
    end
  end

  assign fq_insns = fq_hit ? rd_data[way_q*LINE_W +: LINE_W] : LINE_W'(conv_q);

  assert_hit_delivers_R2: assert property (@(posedge clk) disable iff (rst)
    (accept && lk_hit) |=> (fq_valid && fq_hit));
  assert_miss_goes_busy_R4: assert property (@(posedge clk) disable iff (rst)
    (accept && !lk_hit) |=> (fetch_busy && !fq_valid));
  assert_busy_ignores_R6: assert property (@(posedge clk) disable iff (rst)
    (fetch_req && fetch_busy) |=> ($stable(hit_count) && $stable(miss_count)));
  assert_one_tally_R9: assert property (@(posedge clk) disable iff (rst)
    accept |=> (hit_count + miss_count == $past(hit_count) + $past(miss_count) + 1'b1));
  assert_len_range_R10: assert property (@(posedge clk) disable iff (rst)
    (fq_valid && fq_hit) |-> (fq_count != '0 && fq_count <= LEN_W'(MAX_LEN)));
endmodule

// File: tb/trace_cache_test.sv
module trace_cache_test;
  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [7:0]    miss_delay = 8'd2;
  logic          fetch_req = 1'b0;
  logic [31:0]   fetch_addr = '0;
  logic          fetch_busy;
  logic          fill_valid = 1'b0;
  logic [31:0]   fill_addr = '0;
  logic [4:0]    fill_count = '0;
  logic [31:0]   fill_next = '0;
  logic [511:0]  fill_insns = '0;
  logic [31:0]   conv_addr;
  logic [31:0]   conv_insn;
  logic          fq_valid, fq_hit;
  logic [4:0]    fq_count;
  logic [31:0]   fq_next;
  logic [511:0]  fq_insns;
  logic [31:0]   hit_count, miss_count;

  int n_checks = 0;
  int n_fail   = 0;
  int exp_hits = 0;
  int exp_miss = 0;

  always #4 clk = ~clk;
  assign conv_insn = ~conv_addr;  // stub for the conventional path

  trace_cache uut (
    .clk(clk), .rst(rst), .miss_delay(miss_delay),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_busy(fetch_busy),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_count(fill_count),
    .fill_next(fill_next), .fill_insns(fill_insns),
    .conv_addr(conv_addr), .conv_insn(conv_insn),
    .fq_valid(fq_valid), .fq_hit(fq_hit), .fq_count(fq_count),
    .fq_next(fq_next), .fq_insns(fq_insns),
    .hit_count(hit_count), .miss_count(miss_count)
  );

  function automatic logic [31:0] lane_val(input logic [31:0] a, input int i);
    return (a * 32'h9E37) ^ (32'h0101_0000 * i) ^ 32'h5A5A_0000;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_fill(input logic [31:0] a, input int len);
    @(negedge clk);
    fill_valid = 1'b1;
    fill_addr  = a;
    fill_count = 5'(len);
    fill_next  = a + 32'(len * 4);
    for (int i = 0; i < 16; i++) fill_insns[i*32 +: 32] = lane_val(a, i);
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  // issue a fetch and measure at which cycle after acceptance fq_valid rises
  task automatic do_fetch(input logic [31:0] a, input bit hit, input int len);
    int k;
    int want;
    @(negedge clk);
    fetch_req  = 1'b1;
    fetch_addr = a;
    @(negedge clk);
    fetch_req = 1'b0;
    k = 1;
    if (!hit) check("R4 busy after miss", 32'(fetch_busy), 32'd1);
    while (!fq_valid && k < 300) begin
      @(negedge clk);
      k++;
    end
    want = hit ? 1 : int'(miss_delay) + 2;
    check(hit ? "R2 hit latency" : "R4/R5 miss latency", 32'(k), 32'(want));
    check(hit ? "R3 hit flag" : "R4 miss flag", 32'(fq_hit), 32'(hit));
    if (hit) begin
      exp_hits++;
      check("R10 length", 32'(fq_count), 32'(len));
      check("R2 next", fq_next, a + 32'(len * 4));
      for (int i = 0; i < len; i++) check("R2 lane", fq_insns[i*32 +: 32], lane_val(a, i));
    end else begin
      exp_miss++;
      check("R4 count", 32'(fq_count), 32'd1);
      check("R4 lane0", fq_insns[31:0], ~a);
      check("R4 next", fq_next, a + 32'd4);
      check("R4 busy released", 32'(fetch_busy), 32'd0);
    end
    check("R9 hits", hit_count, 32'(exp_hits));
    check("R9 misses", miss_count, 32'(exp_miss));
  endtask

  // {fill?, address, length, expect hit, pad}; set 5 = address bits [7:2]
  localparam int NV = 19;
  localparam logic [39:0] VEC [NV] = '{
    {1'b1, 32'h0114, 5'd16, 1'b0, 1'b0},
    {1'b1, 32'h0214, 5'd3,  1'b0, 1'b0},
    {1'b1, 32'h0314, 5'd1,  1'b0, 1'b0},
    {1'b1, 32'h0414, 5'd8,  1'b0, 1'b0},
    {1'b0, 32'h0114, 5'd16, 1'b1, 1'b0},  // R3: four tags in one set
    {1'b0, 32'h0214, 5'd3,  1'b1, 1'b0},
    {1'b0, 32'h0314, 5'd1,  1'b1, 1'b0},
    {1'b0, 32'h0414, 5'd8,  1'b1, 1'b0},
    {1'b0, 32'h0514, 5'd0,  1'b0, 1'b0},
    {1'b0, 32'h0118, 5'd0,  1'b0, 1'b0},
    {1'b0, 32'h0114, 5'd16, 1'b1, 1'b0},
    {1'b1, 32'h0514, 5'd5,  1'b0, 1'b0},  // R8: evicts the oldest, 0x0214
    {1'b0, 32'h0214, 5'd0,  1'b0, 1'b0},
    {1'b0, 32'h0514, 5'd5,  1'b1, 1'b0},
    {1'b0, 32'h0114, 5'd16, 1'b1, 1'b0},
    {1'b0, 32'h0314, 5'd1,  1'b1, 1'b0},  // leaves 0x0414 the oldest
    {1'b1, 32'h0314, 5'd12, 1'b0, 1'b0},  // R7: must overwrite its own way
    {1'b0, 32'h0314, 5'd12, 1'b1, 1'b0},
    {1'b0, 32'h0414, 5'd8,  1'b1, 1'b0}
  };

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 busy", 32'(fetch_busy), 32'd0);
    check("R1 fq_valid", 32'(fq_valid), 32'd0);
    check("R1 hits", hit_count, 32'd0);
    check("R1 misses", miss_count, 32'd0);
    rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      if (VEC[v][39]) do_fill(VEC[v][38:7], int'(VEC[v][6:2]));
      else do_fetch(VEC[v][38:7], VEC[v][1], int'(VEC[v][6:2]));
    end

    // R5: zero and larger delays
    miss_delay = 8'd0;
    do_fetch(32'h0718, 1'b0, 0);
    miss_delay = 8'd5;
    do_fetch(32'h0918, 1'b0, 0);

    // R6: a hitting address held on the request pins during a miss
    @(negedge clk);
    fetch_req  = 1'b1;
    fetch_addr = 32'h0818;
    @(negedge clk);
    fetch_addr = 32'h0114;
    exp_miss++;
    for (int c = 2; c <= 6; c++) begin
      @(negedge clk);
      check("R6 no delivery while busy", 32'(fq_valid), 32'd0);
      check("R6 conv address kept", conv_addr, 32'h0818);
    end
    fetch_req = 1'b0;
    @(negedge clk);  // cycle 7 = delay 5 + 2
    check("R6 miss arrives on time", 32'(fq_valid), 32'd1);
    check("R6 miss payload", fq_insns[31:0], ~32'h0818);
    check("R6 hits untouched", hit_count, 32'(exp_hits));
    check("R6 misses", miss_count, 32'(exp_miss));

    // R1: reset in mid-run clears lines and counters
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1 hits after reset", hit_count, 32'd0);
    check("R1 misses after reset", miss_count, 32'd0);
    check("R1 busy after reset", 32'(fetch_busy), 32'd0);
    rst = 1'b0;
    exp_hits = 0;
    exp_miss = 0;
    miss_delay = 8'd1;
    do_fetch(32'h0114, 1'b0, 0);  // R1: line no longer valid

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule